// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block turns a single PWM command into two gate enables for a synchronous half-bridge: a high-side enable that follows PWM and a low-side enable that follows its inverse. It never allows both enables to be on together. The dead time between the two is not a fixed count. It is closed by handshakes with two external comparator flags. One flag reports that the switch node has dropped to near ground. The other reports that the low-side gate has discharged.

When PWM falls, the high side switches off after a programmable delay. The low side then waits for the switch-node-low flag. If that flag never arrives, a safety timeout forces the low side on so that a stuck high-side device cannot push the output up. When PWM rises, the low side switches off after its own delay. The high side then waits, with no time limit, for the low-gate-discharged flag. An enable input parks both outputs low. All delays and the timeout are parameters counted in clock cycles. The PWM input and both flags are resynchronised by two-flop chains before use.

Top module: `dt_gate_seq`

## Requirements
- R1: `gate_hi` and `gate_lo` are never both 1 in the same cycle.
- R2: While `en` is 0 at a rising clock edge, both outputs are 0 after that edge. Once `en` returns to 1, the sequencer restarts from the waiting state that matches the current synchronised PWM level.
- R3: A falling edge of PWM, once seen by the sequencer, keeps `gate_hi` at 1 for HI_OFF_DLY more cycles and then clears it.
- R4: Once the high side is off, `gate_lo` may rise only after `sw_low_in` (1 = switch node low) is seen, and then only after LO_ON_DLY further cycles.
- R5: If the synchronised `sw_low_in` stays 0 for SW_TIMEOUT cycles after `gate_hi` clears, `gate_lo` rises at once, with no LO_ON_DLY, exactly SW_TIMEOUT cycles after `gate_hi` fell.
- R6: A rising edge of PWM, once seen by the sequencer, keeps `gate_lo` at 1 for LO_OFF_DLY more cycles and then clears it.
- R7: Once the low side is off, `gate_hi` rises only after `lg_dis_in` (1 = low gate discharged) is seen, followed by HI_ON_DLY cycles. There is no timeout, so `gate_hi` stays 0 for as long as the flag stays 0.
- R8: If PWM reverses while a turn-on is still waiting on its flag or its delay, that turn-on is abandoned and the opposite transition starts, with both outputs held at 0 meanwhile.
- R9: `pwm_in`, `sw_low_in` and `lg_dis_in` each pass through two flops, so the sequencer acts on an input level at the third rising edge after it was applied.
- R10: While `rst_n` is 0, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | 1 = run, 0 = both gates off |
| pwm_in | input | 1 | PWM command, asynchronous |
| sw_low_in | input | 1 | Comparator: switch node below threshold |
| lg_dis_in | input | 1 | Comparator: low-side gate discharged |
| gate_hi | output | 1 | High-side gate enable |
| gate_lo | output | 1 | Low-side gate enable |

## Verification
The bench targets a switch-node flag stuck at 0. It measures the low-side gap against SW_TIMEOUT, which catches a timer that is off by one or that wrongly adds the turn-on delay. A low-gate flag stuck at 0 must keep the high side off for as long as it holds, so a design that let a timeout leak into that path would turn it on. Short PWM pulses that reverse a pending turn-on expose a sequencer that completes the stale transition and drives the wrong gate. Toggling enable mid-cycle catches outputs that stay high. A cycle-by-cycle model includes the synchronizer latency, so any shift in a single edge shows up as a mismatch.

// File: rtl/dt_gate_seq.sv
module dt_gate_seq #(
  parameter int HI_OFF_DLY = 2,
  parameter int LO_ON_DLY  = 3,
  parameter int LO_OFF_DLY = 2,
  parameter int HI_ON_DLY  = 3,
  parameter int SW_TIMEOUT = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic pwm_in,
  input  logic sw_low_in,
  input  logic lg_dis_in,
  output logic gate_hi,
  output logic gate_lo
);
  localparam int M1 = (HI_OFF_DLY > LO_ON_DLY) ? HI_OFF_DLY : LO_ON_DLY;
  localparam int M2 = (LO_OFF_DLY > HI_ON_DLY) ? LO_OFF_DLY : HI_ON_DLY;
  localparam int M3 = (M1 > M2) ? M1 : M2;
  localparam int MX = (M3 > SW_TIMEOUT) ? M3 : SW_TIMEOUT;
  localparam int CW = $clog2(MX + 1);
  localparam logic [CW-1:0] HOFF_END = CW'(HI_OFF_DLY - 1);
  localparam logic [CW-1:0] LON_END  = CW'(LO_ON_DLY - 1);
  localparam logic [CW-1:0] LOFF_END = CW'(LO_OFF_DLY - 1);
  localparam logic [CW-1:0] HON_END  = CW'(HI_ON_DLY - 1);
  localparam logic [CW-1:0] TMO_END  = CW'(SW_TIMEOUT - 1);

  typedef enum logic [3:0] {
    PARK, HI_ON, HI_FALL, LO_WAIT, LO_RISE, LO_ON, LO_FALL, HI_WAIT, HI_RISE
  } st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic [1:0] p_sy, s_sy, g_sy;
  logic pwm, swl, lgd;

  assign pwm = p_sy[1];
  assign swl = s_sy[1];
  assign lgd = g_sy[1];
  assign gate_hi = (st == HI_ON) || (st == HI_FALL);
  assign gate_lo = (st == LO_ON) || (st == LO_FALL);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      p_sy <= '0;
      s_sy <= '0;
      g_sy <= '0;
    end else begin
      p_sy <= {p_sy[0], pwm_in};
      s_sy <= {s_sy[0], sw_low_in};
      g_sy <= {g_sy[0], lg_dis_in};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st  <= PARK;
      cnt <= '0;
    end else if (!en) begin
      st  <= PARK;
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
      case (st)
        PARK: begin
          st  <= pwm ? HI_WAIT : LO_WAIT;
          cnt <= '0;
        end
        HI_ON: if (!pwm) begin st <= HI_FALL; cnt <= '0; end
        HI_FALL: if (cnt == HOFF_END) begin st <= LO_WAIT; cnt <= '0; end
        LO_WAIT:
          if (pwm)                  begin st <= HI_WAIT; cnt <= '0; end
          else if (swl)             begin st <= LO_RISE; cnt <= '0; end
          else if (cnt == TMO_END)  begin st <= LO_ON;   cnt <= '0; end
        LO_RISE:
          if (pwm)                  begin st <= HI_WAIT; cnt <= '0; end
          else if (cnt == LON_END)  begin st <= LO_ON;   cnt <= '0; end
        LO_ON: if (pwm) begin st <= LO_FALL; cnt <= '0; end
        LO_FALL: if (cnt == LOFF_END) begin st <= HI_WAIT; cnt <= '0; end
        HI_WAIT:
          if (!pwm)                 begin st <= LO_WAIT; cnt <= '0; end
          else if (lgd)             begin st <= HI_RISE; cnt <= '0; end
        HI_RISE:
          if (!pwm)                 begin st <= LO_WAIT; cnt <= '0; end
          else if (cnt == HON_END)  begin st <= HI_ON;   cnt <= '0; end
        default: begin st <= PARK; cnt <= '0; end
      endcase
    end

  // R1
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo));
  // R2
  en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!gate_hi && !gate_lo));
  // R7
  hi_rise_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_hi) |-> $past(p_sy[1]));
  // R4
  lo_rise_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_lo) |-> !$past(p_sy[1]));
  // R8
  hi_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_hi) |-> !$past(gate_lo));
  // R8
  lo_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_lo) |-> !$past(gate_hi));
endmodule

// File: tb/tb_dt_gate_seq.sv
module tb_dt_gate_seq;
  localparam int CLK_PERIOD = 10;
  localparam int HOFF = 2, LON = 3, LOFF = 2, HON = 3, TMO = 30;

  logic clk = 0, rst_n = 0, en = 0, pwm_in = 0, sw_low_in = 0, lg_dis_in = 0;
  logic gate_hi, gate_lo;
  int n_chk = 0, n_bad = 0, cyc = 0;
  bit sw_stuck = 0, lg_stuck = 0;

  dt_gate_seq #(.HI_OFF_DLY(HOFF), .LO_ON_DLY(LON), .LO_OFF_DLY(LOFF),
                .HI_ON_DLY(HON), .SW_TIMEOUT(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .pwm_in(pwm_in),
    .sw_low_in(sw_low_in), .lg_dis_in(lg_dis_in),
    .gate_hi(gate_hi), .gate_lo(gate_lo));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference: phase code and a countdown
  int ph = 0, rem = 0, tw = 0;
  bit mp1, mp2, ms1, ms2, mg1, mg2;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; rem = 0; tw = 0;
      {mp1, mp2, ms1, ms2, mg1, mg2} = '0;
    end else begin
      if (!en) ph = 0;
      else case (ph)
        0: begin ph = mp2 ? 7 : 3; tw = 0; end
        1: if (!mp2) begin ph = 2; rem = HOFF; end
        2: begin rem--; if (rem == 0) begin ph = 3; tw = 0; end end
        3: if (mp2) ph = 7;
           else begin
             tw++;
             if (ms2) begin ph = 4; rem = LON; end
             else if (tw >= TMO) ph = 5;
           end
        4: if (mp2) ph = 7; else begin rem--; if (rem == 0) ph = 5; end
        5: if (mp2) begin ph = 6; rem = LOFF; end
        6: begin rem--; if (rem == 0) ph = 7; end
        7: if (!mp2) begin ph = 3; tw = 0; end
           else if (mg2) begin ph = 8; rem = HON; end
        8: if (!mp2) begin ph = 3; tw = 0; end
           else begin rem--; if (rem == 0) ph = 1; end
        default: ph = 0;
      endcase
      mp2 = mp1; mp1 = pwm_in;
      ms2 = ms1; ms1 = sw_low_in;
      mg2 = mg1; mg1 = lg_dis_in;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // per-cycle comparison and external plant
  int gap = 0;
  bit meas = 0, gap_on = 0;
  bit prev_hi = 0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      check(gate_hi == (ph == 1 || ph == 2), "R3 R7 R9 gate_hi", gate_hi, (ph == 1 || ph == 2));
      check(gate_lo == (ph == 5 || ph == 6), "R4 R6 R9 gate_lo", gate_lo, (ph == 5 || ph == 6));
      check(!(gate_hi && gate_lo), "R1 overlap", gate_hi & gate_lo, 0);
      if (meas) begin
        if (prev_hi && !gate_hi) begin gap_on = 1; gap = 1; end
        else if (gap_on && !gate_lo) gap++;
        else if (gap_on && gate_lo) begin
          check(gap == TMO, "R5 timeout gap", gap, TMO);
          gap_on = 0; meas = 0;
        end
      end
      prev_hi = gate_hi;
    end
    sw_low_in = sw_stuck ? 1'b0 : !gate_hi;
    lg_dis_in = lg_stuck ? 1'b0 : !gate_lo;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, 20000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic pwm_run(input int hi_len, input int lo_len, input int reps);
    for (int i = 0; i < reps; i++) begin
      pwm_in = 1; repeat (hi_len) @(negedge clk);
      pwm_in = 0; repeat (lo_len) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10
    check(!gate_hi && !gate_lo, "R10 reset outputs", {gate_hi, gate_lo}, 0);
    rst_n = 1; en = 1;
    repeat (60) @(negedge clk);
    pwm_run(20, 20, 4);
    pwm_run(40, 9, 3);
    pwm_run(7, 30, 3);
    // R8: short reversals during pending turn-ons
    pwm_run(3, 3, 6);
    pwm_run(1, 5, 4);
    pwm_run(12, 2, 4);
    pwm_in = 0; repeat (40) @(negedge clk);
    // R5: switch node never reported low
    sw_stuck = 1;
    pwm_in = 1; repeat (30) @(negedge clk);
    meas = 1;
    pwm_in = 0; repeat (TMO + 20) @(negedge clk);
    check(!meas, "R5 timeout reached", meas, 0);
    sw_stuck = 0;
    // R7: low gate never discharged
    lg_stuck = 1;
    pwm_in = 1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (gate_hi) check(0, "R7 no timeout on high path", gate_hi, 0);
    end
    check(!gate_hi, "R7 high stays off", gate_hi, 0);
    // R8: abandon the high turn-on when PWM falls
    pwm_in = 0; repeat (20) @(negedge clk);
    check(gate_lo, "R8 abort to low side", gate_lo, 1);
    lg_stuck = 0;
    pwm_in = 1; repeat (30) @(negedge clk);
    // R2: disable while high side on
    check(gate_hi, "R2 precondition high on", gate_hi, 1);
    en = 0; @(negedge clk);
    check(!gate_hi && !gate_lo, "R2 disabled outputs", {gate_hi, gate_lo}, 0);
    for (int i = 0; i < 12; i++) begin
      pwm_in = i[0]; @(negedge clk);
      if (gate_hi || gate_lo) check(0, "R2 stays off", {gate_hi, gate_lo}, 0);
    end
    en = 1; pwm_in = 0;
    repeat (30) @(negedge clk);
    check(gate_lo, "R2 restart low side", gate_lo, 1);
    pwm_run(15, 15, 3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule